// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to an 8-bit processor core and takes over the bus while the core enters an interrupt handler or a software break. Every clock it samples a small set of prioritised request lines. A timer request and two external requests are provided by default. The lines are masked by the interrupt-disable bit of the core's status register, and the masked result is held in a pending register.

When the core signals that its current instruction has finished, the block decides whether to enter. A pending request, or a break flagged by the core, starts a fixed sequence of bus cycles. The sequence makes discarded reads at the unchanged program counter, stacks the return address and the status byte, rewrites the status flags and fetches a 16-bit handler address. Finally it loads that address into the program counter.

The core supplies its current PC, status and stack pointer. The block hands back new values through write strobes, and the core applies them at the clock edge. Instruction decode and execution belong to the core.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `busRd`, `busWr`, `pcWe`, `statusWe` and `spWe` are all low, and a read and a write are never driven in the same cycle.
- R2: Requests are sampled every cycle and count as absent while status bit 2 (interrupt disable) is 1, so a request that is only present while that bit is set never starts a sequence.
- R3: A sequence starts only in the cycle after `instrDone` is high with a request pending or `brkReq` high. Requests without `instrDone` start nothing, and `instrDone` and `brkReq` are ignored while `busy` is high.
- R4: A hardware entry is 10 bus cycles long with `busy` high throughout. The first three are reads at the unchanged PC, and two more reads at that PC come between the second and third pushes.
- R5: A break (`brkReq` high with `instrDone`) is taken whatever the disable bit holds. It skips the first two reads, so it lasts 8 cycles.
- R6: Each push writes to address {STACK_PAGE, SP} and then lowers SP by one through `spWe`/`spNew`. The return PC is pushed high byte first, then low byte, and the status byte is pushed third, so SP ends 3 below its start.
- R7: The pushed status byte is the current status with bit 4 (break) set for a break and cleared for a hardware entry. All other bits, including bit 3 (decimal) and bit 5 (memory mode), are pushed as they are.
- R8: In the status-push cycle `statusWe` writes the status with bits 3 and 5 cleared and bit 2 set, all other bits unchanged.
- R9: The handler address is taken from the pending source of lowest index (index 0 timer at 0xFFFA, index 1 at 0xFFF8, index 2 at 0xFFF6). A break always uses the index 2 address.
- R10: The pending set is committed when the sequence starts. Requests that drop in the `instrDone` cycle, or that change during the sequence, do not alter the vector taken.
- R11: The vector is read low byte from the vector address and high byte from the next address. In the last cycle `pcWe` loads {high, low} into the PC, and `busy` falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 3 | Request lines, index 0 highest priority |
| instrDone | input | 1 | Current instruction's last cycle |
| brkReq | input | 1 | Finishing instruction is a software break |
| cpuPc | input | 16 | Core program counter |
| cpuStatus | input | 8 | Core status register |
| cpuSp | input | 8 | Core stack pointer |
| busAddr | output | 16 | Bus address |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, valid in the same cycle |
| pcWe | output | 1 | Load PC |
| pcNew | output | 16 | New PC value |
| statusWe | output | 1 | Load status |
| statusNew | output | 8 | New status value |
| spWe | output | 1 | Load stack pointer |
| spNew | output | 8 | New stack pointer value |
| busy | output | 1 | Entry sequence in progress |

## Verification
A wrong state in the sequencer shows up within one cycle at the bus. A skipped or repeated step gives a read where a write was expected, or an address off by one stack slot. A corrupt latched source index or stale captured status stays hidden until the final stack write or the vector fetch, up to ten cycles after the start. It is then visible as a wrong status byte on the stack or a wrong vector address. A pending register that ignores the mask shows only as an extra entry after the next finished instruction, so the bench follows masked and break cases with idle cycles in which any bus cycle is an error.

// File: rtl/irq_entry_pkg.sv
`timescale 1ns/1ps
package irq_entry_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DISC0, S_DISC1, S_DISC2, S_PUSH_HI, S_PUSH_LO,
    S_DISC3, S_DISC4, S_PUSH_ST, S_VEC_LO, S_VEC_HI
  } seq_state_e;

  typedef struct packed {
    logic capture;
    logic isBrk;
    logic dummyRd;
    logic pushHi;
    logic pushLo;
    logic pushSt;
    logic vecLo;
    logic vecHi;
  } seq_strobe_t;

  localparam int FLAG_I = 2;
  localparam int FLAG_D = 3;
  localparam int FLAG_B = 4;
  localparam int FLAG_T = 5;

endpackage

// File: rtl/irq_entry_ctrl.sv
`timescale 1ns/1ps
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrDone,
  input  logic        brkReq,
  input  logic        anyPend,
  output seq_strobe_t strb,
  output logic        busy
);

  seq_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (instrDone) begin
          if (brkReq) begin
            strb.capture = 1'b1;
            strb.isBrk   = 1'b1;
            stateNext    = S_DISC2;
          end else if (anyPend) begin
            strb.capture = 1'b1;
            stateNext    = S_DISC0;
          end
        end
      end
      S_DISC0:   begin strb.dummyRd = 1'b1; stateNext = S_DISC1;   end
      S_DISC1:   begin strb.dummyRd = 1'b1; stateNext = S_DISC2;   end
      S_DISC2:   begin strb.dummyRd = 1'b1; stateNext = S_PUSH_HI; end
      S_PUSH_HI: begin strb.pushHi  = 1'b1; stateNext = S_PUSH_LO; end
      S_PUSH_LO: begin strb.pushLo  = 1'b1; stateNext = S_DISC3;   end
      S_DISC3:   begin strb.dummyRd = 1'b1; stateNext = S_DISC4;   end
      S_DISC4:   begin strb.dummyRd = 1'b1; stateNext = S_PUSH_ST; end
      S_PUSH_ST: begin strb.pushSt  = 1'b1; stateNext = S_VEC_LO;  end
      S_VEC_LO:  begin strb.vecLo   = 1'b1; stateNext = S_VEC_HI;  end
      S_VEC_HI:  begin strb.vecHi   = 1'b1; stateNext = S_IDLE;    end
      default:   stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R3: entry only follows a finished instruction
  a_r3_start_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(instrDone));

  // R11: the sequence ends right after the high vector byte
  a_r11_end_after_vec: assert property (@(posedge clk) disable iff (!rstN)
    strb.vecHi |=> !busy);

endmodule

// File: rtl/irq_entry_dp.sv
`timescale 1ns/1ps
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_SRC = 3,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 8'h21,
  parameter logic [NUM_SRC*ADDR_W-1:0] VEC_TABLE = {16'hFFF6, 16'hFFF8, 16'hFFFA}
) (
  input  logic               clk,
  input  logic               rstN,
  input  seq_strobe_t        strb,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [ADDR_W-1:0]  cpuPc,
  input  logic [DATA_W-1:0]  cpuStatus,
  input  logic [DATA_W-1:0]  cpuSp,
  input  logic [DATA_W-1:0]  busRdata,
  output logic               anyPend,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               busRd,
  output logic               busWr,
  output logic [DATA_W-1:0]  busWdata,
  output logic               pcWe,
  output logic [ADDR_W-1:0]  pcNew,
  output logic               statusWe,
  output logic [DATA_W-1:0]  statusNew,
  output logic               spWe,
  output logic [DATA_W-1:0]  spNew
);

  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [SEL_W-1:0] BRK_SEL = SEL_W'(NUM_SRC - 1);

  logic [NUM_SRC-1:0] pendReg;
  logic [SEL_W-1:0]   selReg, prioIdx;
  logic               brkReg;
  logic [ADDR_W-1:0]  pcReg, vecAddr;
  logic [DATA_W-1:0]  stReg, spReg, vecLoReg, pushedSt;

  // requests are masked while interrupts are disabled
  always_ff @(posedge clk) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= cpuStatus[FLAG_I] ? '0 : irqReq;
  end

  assign anyPend = |pendReg;

  always_comb begin
    prioIdx = BRK_SEL;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendReg[i]) prioIdx = SEL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      brkReg   <= 1'b0;
      pcReg    <= '0;
      stReg    <= '0;
      spReg    <= '0;
      vecLoReg <= '0;
    end else begin
      if (strb.capture) begin
        selReg <= strb.isBrk ? BRK_SEL : prioIdx;
        brkReg <= strb.isBrk;
        pcReg  <= cpuPc;
        stReg  <= cpuStatus;
        spReg  <= cpuSp;
      end
      if (strb.pushHi || strb.pushLo || strb.pushSt) spReg <= spReg - 1'b1;
      if (strb.vecLo) vecLoReg <= busRdata;
    end
  end

  assign vecAddr = VEC_TABLE[int'(selReg)*ADDR_W +: ADDR_W];

  always_comb begin
    pushedSt         = stReg;
    pushedSt[FLAG_B] = brkReg;
  end

  always_comb begin
    busAddr  = pcReg;
    busWdata = '0;
    busRd    = strb.dummyRd | strb.vecLo | strb.vecHi;
    busWr    = strb.pushHi | strb.pushLo | strb.pushSt;
    if (busWr) busAddr = {STACK_PAGE, spReg};
    if (strb.pushHi) busWdata = pcReg[ADDR_W-1:DATA_W];
    if (strb.pushLo) busWdata = pcReg[DATA_W-1:0];
    if (strb.pushSt) busWdata = pushedSt;
    if (strb.vecLo)  busAddr  = vecAddr;
    if (strb.vecHi)  busAddr  = vecAddr + 1'b1;
  end

  always_comb begin
    statusNew         = stReg;
    statusNew[FLAG_D] = 1'b0;
    statusNew[FLAG_T] = 1'b0;
    statusNew[FLAG_I] = 1'b1;
  end

  assign statusWe = strb.pushSt;
  assign spWe     = busWr;
  assign spNew    = spReg - 1'b1;
  assign pcWe     = strb.vecHi;
  assign pcNew    = {busRdata, vecLoReg};

  // R1: one bus direction per cycle
  a_r1_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R6: every write lands in the stack page
  a_r6_stack_page: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> busAddr[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R11: PC load follows a read of the preceding vector byte
  a_r11_vec_pair: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |-> $past(busRd) && busAddr == $past(busAddr) + 1'b1);

  // R10: committed source holds through the vector fetch
  a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    strb.vecHi |-> $stable(selReg));

endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_SRC = 3,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 8'h21,
  parameter logic [NUM_SRC*ADDR_W-1:0] VEC_TABLE = {16'hFFF6, 16'hFFF8, 16'hFFFA}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               instrDone,
  input  logic               brkReq,
  input  logic [ADDR_W-1:0]  cpuPc,
  input  logic [DATA_W-1:0]  cpuStatus,
  input  logic [DATA_W-1:0]  cpuSp,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               busRd,
  output logic               busWr,
  output logic [DATA_W-1:0]  busWdata,
  input  logic [DATA_W-1:0]  busRdata,
  output logic               pcWe,
  output logic [ADDR_W-1:0]  pcNew,
  output logic               statusWe,
  output logic [DATA_W-1:0]  statusNew,
  output logic               spWe,
  output logic [DATA_W-1:0]  spNew,
  output logic               busy
);

  seq_strobe_t strb;
  logic        anyPend;

  irq_entry_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrDone (instrDone),
    .brkReq    (brkReq),
    .anyPend   (anyPend),
    .strb      (strb),
    .busy      (busy)
  );

  irq_entry_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_SRC    (NUM_SRC),
    .STACK_PAGE (STACK_PAGE),
    .VEC_TABLE  (VEC_TABLE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .irqReq    (irqReq),
    .cpuPc     (cpuPc),
    .cpuStatus (cpuStatus),
    .cpuSp     (cpuSp),
    .busRdata  (busRdata),
    .anyPend   (anyPend),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .busWdata  (busWdata),
    .pcWe      (pcWe),
    .pcNew     (pcNew),
    .statusWe  (statusWe),
    .statusNew (statusNew),
    .spWe      (spWe),
    .spNew     (spNew)
  );

endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;

  typedef struct {
    bit          wr;
    logic [15:0] a;
    logic [7:0]  d;
    string       tag;
  } bus_op_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  irqReq = '0;
  logic        instrDone = 1'b0, brkReq = 1'b0;
  logic [15:0] pc;
  logic [7:0]  st, sp;
  logic [15:0] busAddr, pcNew;
  logic        busRd, busWr, pcWe, statusWe, spWe, busy;
  logic [7:0]  busWdata, busRdata, statusNew, spNew;

  int checks = 0, fails = 0;
  bit finished = 0;
  bus_op_t expQ[$];

  always #2.5 clk = ~clk;

  irq_entry_seq uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .instrDone(instrDone), .brkReq(brkReq),
    .cpuPc(pc), .cpuStatus(st), .cpuSp(sp),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .pcWe(pcWe), .pcNew(pcNew), .statusWe(statusWe), .statusNew(statusNew),
    .spWe(spWe), .spNew(spNew), .busy(busy)
  );

  function automatic logic [7:0] memByte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign busRdata = busRd ? memByte(busAddr) : 8'h00;

  // core register model
  always @(posedge clk) begin
    if (pcWe)     pc <= pcNew;
    if (statusWe) st <= statusNew;
    if (spWe)     sp <= spNew;
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && (busRd || busWr)) begin
      if (expQ.size() == 0) begin
        chk(0, "R3", "unexpected bus cycle at addr", {16'h0, busAddr}, 32'h0);
      end else begin
        bus_op_t it;
        it = expQ.pop_front();
        chk(it.wr == busWr && it.a == busAddr && (!it.wr || it.d == busWdata), it.tag,
            "bus op {wr,addr,data}", {7'h0, busWr, busAddr, busWdata}, {7'h0, it.wr, it.a, it.d});
      end
    end
  end

  task automatic pushOp(bit wr, logic [15:0] a, logic [7:0] d, string tag);
    bus_op_t it;
    it.wr = wr; it.a = a; it.d = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  // vec: expected vector address; drop: lines drop with instrDone;
  // midTimer: raise timer mid-sequence; pokeBrk: break request mid-sequence
  task automatic runSeq(logic [2:0] req, bit brk, logic [15:0] vec, bit drop,
                        bit midTimer, bit pokeBrk, string tag);
    logic [15:0] pc0 = pc;
    logic [7:0]  st0 = st, sp0 = sp, stPush;
    int cnt = 0;
    stPush = st0;
    stPush[4] = brk;
    if (!brk) begin
      pushOp(0, pc0, 0, "R4"); pushOp(0, pc0, 0, "R4");
    end
    pushOp(0, pc0, 0, brk ? "R5" : "R4");
    pushOp(1, {8'h21, sp0}, pc0[15:8], "R6");
    pushOp(1, {8'h21, sp0 - 8'd1}, pc0[7:0], "R6");
    pushOp(0, pc0, 0, "R4"); pushOp(0, pc0, 0, "R4");
    pushOp(1, {8'h21, sp0 - 8'd2}, stPush, "R7");
    pushOp(0, vec, 0, "R9");
    pushOp(0, vec + 16'd1, 0, "R11");
    irqReq = req;
    @(negedge clk);
    @(negedge clk);
    instrDone = 1'b1; brkReq = brk;
    if (drop) irqReq = '0;
    @(negedge clk);
    instrDone = 1'b0; brkReq = 1'b0;
    while (busy && cnt < 20) begin
      cnt++;
      if (cnt == 3 && midTimer) irqReq[0] = 1'b1;
      if (cnt == 4 && pokeBrk) begin instrDone = 1'b1; brkReq = 1'b1; end
      if (cnt == 5) begin instrDone = 1'b0; brkReq = 1'b0; end
      @(negedge clk);
    end
    irqReq = '0;
    chk(cnt == (brk ? 8 : 10), brk ? "R5" : "R4", {tag, " busy length"}, cnt, brk ? 8 : 10);
    chk(pc == {memByte(vec + 16'd1), memByte(vec)}, "R11", {tag, " loaded PC"}, pc,
        {memByte(vec + 16'd1), memByte(vec)});
    chk(st == ((st0 & 8'hD7) | 8'h04), "R8", {tag, " new status"}, st, (st0 & 8'hD7) | 8'h04);
    chk(sp == sp0 - 8'd3, "R6", {tag, " final SP"}, sp, sp0 - 8'd3);
    repeat (3) @(negedge clk);
    chk(!busy && expQ.size() == 0, "R3", {tag, " idle after, ops left"}, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic setCore(logic [15:0] p, logic [7:0] s, logic [7:0] q);
    pc = p; st = s; sp = q;
  endtask

  initial begin
    setCore(16'h1234, 8'h04, 8'hFF);
    repeat (3) @(negedge clk);
    chk(!busy && !busRd && !busWr && !pcWe && !statusWe && !spWe, "R1", "reset outputs",
        {26'h0, busy, busRd, busWr, pcWe, statusWe, spWe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: requests without instrDone start nothing
    setCore(16'h1234, 8'h00, 8'hFF);
    irqReq = 3'b111;
    repeat (6) @(negedge clk);
    chk(!busy, "R3", "no start without instrDone", busy, 0);
    irqReq = '0;
    @(negedge clk);

    // R9: timer only, decimal and memory bits set (R7, R8)
    setCore(16'h8123, 8'h28, 8'hF0);
    runSeq(3'b001, 0, 16'hFFFA, 0, 0, 0, "timer");
    // R9: ext1 beats ext2
    setCore(16'h4000, 8'hC1, 8'h80);
    runSeq(3'b110, 0, 16'hFFF8, 0, 0, 0, "ext1");
    // R9: ext2 alone
    setCore(16'hA5A5, 8'h13, 8'h02);
    runSeq(3'b100, 0, 16'hFFF6, 0, 0, 0, "ext2");
    // R9: all pending -> timer
    setCore(16'h0001, 8'h00, 8'h00);
    runSeq(3'b111, 0, 16'hFFFA, 0, 0, 0, "all");
    // R5: break with interrupts disabled, B pushed set (R7)
    setCore(16'h2222, 8'h2C, 8'h40);
    runSeq(3'b000, 1, 16'hFFF6, 0, 0, 0, "break");
    // R10: lines drop in the instrDone cycle, still taken
    setCore(16'h3000, 8'h00, 8'h50);
    runSeq(3'b010, 0, 16'hFFF8, 1, 0, 0, "late drop");
    // R10: timer raised mid-sequence does not change ext2 vector;
    // R3: break poke while busy ignored
    setCore(16'h5000, 8'h08, 8'h60);
    runSeq(3'b100, 0, 16'hFFF6, 0, 1, 1, "mid change");

    // R2: masked request never starts
    setCore(16'h6000, 8'h04, 8'h70);
    irqReq = 3'b111;
    repeat (2) @(negedge clk);
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && pc == 16'h6000 && sp == 8'h70, "R2", "masked request ignored",
        {15'h0, busy, pc}, {16'h0, 16'h6000});
    irqReq = '0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule